// File: doc/BRIEF.md
# Dual-Host Secondary Interrupt Bank

This block gathers up to a few dozen peripheral event inputs and reports them to two independent host interrupt lines. Every source first passes through a two-stage synchroniser. A per-source edge selection then decides whether a rising edge, a falling edge, both edges or no edge counts as an event. The edge selection is shared by both hosts. Each host line keeps its own status bits and its own mask bits. It drives an active-low summary output that can feed a primary interrupt aggregator.

Software reaches all state through a byte-wide register port. A one-bit control setting chooses how status is acknowledged. In write-one-to-clear mode, status is cleared by writing ones. In clear-on-read mode, reading a status byte clears the bits that the read returned. A second event that arrives while a status bit is already set is held in a one-deep pending slot. That slot refills the status bit once the bit is acknowledged, so the host does not lose the event.

Registers, from offset 0 (defaults: 22 sources, 3 status bytes, 6 edge bytes): edge bytes 0-5, host-1 status 6-8, host-1 mask 9-11, host-2 status 12-14, host-2 mask 15-17, control 18 (bit 0 selects clear-on-read).

Top module: `dual_host_irq_bank`

## Requirements
- R1: After reset every mask bit reads 1, every edge bit reads 0, every status bit reads 0, the control byte reads 0 and both host_irq_n outputs are high.
- R2: Source i is configured in edge byte i/4. Its falling-edge enable is bit (i mod 4)*2 and its rising-edge enable is the bit one above. An enabled edge sets status bit i (byte i/8, bit i mod 8). A source whose two enable bits are both 0 never sets status.
- R3: The two host lines have separate status and mask registers. An event sets the status bit on both lines, and acknowledging one line leaves the other line unchanged.
- R4: host_irq_n[l] is low exactly when line l has a status bit that is set and whose mask bit is 0.
- R5: With control bit 0 cleared, writing 1 to a status bit clears it, writing 0 leaves it unchanged, and reads do not alter status.
- R6: With control bit 0 set, reading a status byte clears the bits it returned, and writes to status bytes have no effect.
- R7: An event on a source whose status bit is already set is buffered. After the bit is acknowledged it reads as set once more, and a further acknowledge clears it.
- R8: When a clear-on-read of a status bit and a new event on that bit occur in the same cycle, the bit remains set and no extra pending event is kept.
- R9: Status bits at or above the source count read 0. Edge bits above 2×source count read 0 whatever was written. Unmapped offsets read 0.
- R10: reg_rdata holds the value of the addressed register from the cycle in which reg_rd was high. It is valid from the following cycle until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NSRC | Asynchronous peripheral event inputs |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| host_irq_n | output | 2 | Active-low summary interrupt per host line |

## Verification
The bench targets the clear-on-read race, where an edge reaches the synchroniser output in the same cycle as the read. A design that let the clear win would drop that event, and the following read would return 0 instead of 1. A second edge while status is set must come back after the first acknowledge; a design without the pending slot returns 0 on the second read. Both edges are checked with separate polarity bits, so a design with the rising and falling enables swapped sets status on the wrong edge. The bench also checks that a status write in clear-on-read mode is ignored, and that an acknowledge on one host line leaves the other line's status set. Finally it checks that the padding bits of the last status byte and of the last edge byte read as zero.

// File: rtl/irqc_pkg.sv
// Shared sizing helpers for the dual-host interrupt bank.
// Assumes the register map is laid out as: edge bytes, then per line a
// status block and a mask block, then one control byte.
package irqc_pkg;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // bytes holding the two edge-enable bits of every source
    function automatic int edge_bytes(input int nsrc);
        return cdiv(2 * nsrc, 8);
    endfunction

    // bytes of one status or mask register
    function automatic int ix_bytes(input int nsrc);
        return cdiv(nsrc, 8);
    endfunction

    function automatic int stat_ofs(input int nsrc, input int line);
        return edge_bytes(nsrc) + 2 * line * ix_bytes(nsrc);
    endfunction

    function automatic int mask_ofs(input int nsrc, input int line);
        return stat_ofs(nsrc, line) + ix_bytes(nsrc);
    endfunction

    function automatic int ctrl_ofs(input int nsrc);
        return edge_bytes(nsrc) + 4 * ix_bytes(nsrc);
    endfunction

endpackage

// File: rtl/irqc_sync_edge.sv
// Synchronises each asynchronous source through two flops and compares the
// result with its value one cycle earlier. An event pulse is raised for one
// cycle on every edge whose direction is enabled in edge_cfg (bit 2i+1 =
// rising, bit 2i = falling). Assumes sources are stable for 2+ cycles.
module irqc_sync_edge #(
    parameter int NSRC = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_in,
    input  logic [2*NSRC-1:0]   edge_cfg,
    output logic [NSRC-1:0]     ev
);

    logic [NSRC-1:0] meta_q;
    logic [NSRC-1:0] sync_q;
    logic [NSRC-1:0] prev_q;

    // two-flop synchroniser followed by a one-cycle history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic rise;
        logic fall;
        assign rise  = sync_q[i] & ~prev_q[i];
        assign fall  = ~sync_q[i] & prev_q[i];
        assign ev[i] = (rise & edge_cfg[2*i+1]) | (fall & edge_cfg[2*i]);
    end

endmodule

// File: rtl/irqc_line_bank.sv
// Status, one-deep pending and mask state for one host line, plus that
// line's active-low summary output. Assumes the caller decodes byte
// selects; wr and rd are the raw register strobes.
module irqc_line_bank #(
    parameter int NSRC = 22,
    parameter int NB   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  ev,
    input  logic             cor,
    input  logic             wr,
    input  logic             rd,
    input  logic [7:0]       wdata,
    input  logic [NB-1:0]    stat_sel,
    input  logic [NB-1:0]    mask_sel,
    output logic [NSRC-1:0]  stat,
    output logic [NSRC-1:0]  mask,
    output logic             irq_n
);

    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] mask_we;

    // per-bit acknowledge and mask-write strobes
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        assign clr[i] = stat_sel[i/8] &
                        ((cor & rd & stat_q[i]) | (~cor & wr & wdata[i%8]));
        assign mask_we[i] = mask_sel[i/8] & wr;
    end

    // status capture: event wins over clear, pending refills on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            pend_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | ev | (pend_q & clr);
            pend_q <= (pend_q & (~clr | ev)) | (ev & stat_q & ~clr);
        end
    end

    // mask register, all sources disabled after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (mask_we[i]) mask_q[i] <= wdata[i%8];
            end
        end
    end

    assign stat  = stat_q;
    assign mask  = mask_q;
    assign irq_n = ~|(stat_q & ~mask_q);

endmodule

// File: rtl/dual_host_irq_bank.sv
// Top of the dual-host secondary interrupt bank: shared edge-select
// register, control register, register decode and read mux, and one line
// bank per host. Assumes ADDR_W covers the control offset.
module dual_host_irq_bank #(
    parameter int NSRC   = 22,
    parameter int ADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    src_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic [1:0]         host_irq_n
);

    localparam int NB    = irqc_pkg::ix_bytes(NSRC);
    localparam int NE    = irqc_pkg::edge_bytes(NSRC);
    localparam int SW    = NB * 8;
    localparam int EW    = NE * 8;
    localparam int CTRLO = irqc_pkg::ctrl_ofs(NSRC);

    logic [EW-1:0]    edge_q;
    logic [EW-1:0]    edge_valid;
    logic             cor_q;
    logic [NSRC-1:0]  ev_v;
    logic [7:0]       rd_val;
    logic [7:0]       rdata_q;
    logic [NB-1:0]    stat_sel [2];
    logic [NB-1:0]    mask_sel [2];
    logic [NSRC-1:0]  stat_l   [2];
    logic [NSRC-1:0]  mask_l   [2];
    logic [SW-1:0]    stat_pad [2];
    logic [SW-1:0]    mask_pad [2];

    // constant map of implemented edge bits
    for (genvar k = 0; k < EW; k++) begin : g_evalid
        assign edge_valid[k] = (k < 2 * NSRC);
    end

    // shared edge-select register, unimplemented bits kept at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else if (reg_wr) begin
            for (int e = 0; e < NE; e++) begin
                if (reg_addr == ADDR_W'(e))
                    edge_q[e*8 +: 8] <= reg_wdata & edge_valid[e*8 +: 8];
            end
        end
    end

    // control register: bit 0 selects clear-on-read
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cor_q <= 1'b0;
        else if (reg_wr && reg_addr == ADDR_W'(CTRLO)) cor_q <= reg_wdata[0];
    end

    irqc_sync_edge #(.NSRC(NSRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .edge_cfg (edge_q[2*NSRC-1:0]),
        .ev       (ev_v)
    );

    for (genvar l = 0; l < 2; l++) begin : g_line
        for (genvar b = 0; b < NB; b++) begin : g_sel
            assign stat_sel[l][b] =
                (reg_addr == ADDR_W'(irqc_pkg::stat_ofs(NSRC, l) + b));
            assign mask_sel[l][b] =
                (reg_addr == ADDR_W'(irqc_pkg::mask_ofs(NSRC, l) + b));
        end

        irqc_line_bank #(.NSRC(NSRC), .NB(NB)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev_v),
            .cor      (cor_q),
            .wr       (reg_wr),
            .rd       (reg_rd),
            .wdata    (reg_wdata),
            .stat_sel (stat_sel[l]),
            .mask_sel (mask_sel[l]),
            .stat     (stat_l[l]),
            .mask     (mask_l[l]),
            .irq_n    (host_irq_n[l])
        );

        // pad to whole bytes: status pads read 0, mask pads read 1
        for (genvar k = 0; k < SW; k++) begin : g_pad
            if (k < NSRC) begin : g_real
                assign stat_pad[l][k] = stat_l[l][k];
                assign mask_pad[l][k] = mask_l[l][k];
            end else begin : g_fill
                assign stat_pad[l][k] = 1'b0;
                assign mask_pad[l][k] = 1'b1;
            end
        end
    end

    // read mux over the whole map, unmapped offsets give zero
    always_comb begin
        rd_val = '0;
        for (int e = 0; e < NE; e++) begin
            if (reg_addr == ADDR_W'(e)) rd_val = edge_q[e*8 +: 8];
        end
        for (int l = 0; l < 2; l++) begin
            for (int b = 0; b < NB; b++) begin
                if (reg_addr == ADDR_W'(irqc_pkg::stat_ofs(NSRC, l) + b))
                    rd_val = stat_pad[l][b*8 +: 8];
                if (reg_addr == ADDR_W'(irqc_pkg::mask_ofs(NSRC, l) + b))
                    rd_val = mask_pad[l][b*8 +: 8];
            end
        end
        if (reg_addr == ADDR_W'(CTRLO)) rd_val = {7'b0, cor_q};
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_val;
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/dual_host_irq_bank_chk.sv
// Property checker for dual_host_irq_bank, attached with bind below.
// Observes host line 1 status/pending state and the register port.
module dual_host_irq_bank_chk #(
    parameter int NSRC   = 22,
    parameter int ADDR_W = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic                         reg_wr,
    input logic                         reg_rd,
    input logic [7:0]                   reg_rdata,
    input logic [1:0]                   host_irq_n,
    input logic                         cor,
    input logic [NSRC-1:0]              ev,
    input logic [irqc_pkg::ix_bytes(NSRC)*8-1:0] stat0,
    input logic [NSRC-1:0]              pend0
);

    localparam int NB = irqc_pkg::ix_bytes(NSRC);
    localparam int SW = NB * 8;
    localparam int S1 = irqc_pkg::stat_ofs(NSRC, 0);

    logic [SW-1:0] pend_x;
    logic [SW-1:0] ev_x;
    logic          s1_hit0;
    logic          s1_any;

    assign pend_x  = SW'(pend0);
    assign ev_x    = SW'(ev);
    assign s1_hit0 = (reg_addr == ADDR_W'(S1));
    assign s1_any  = (int'(reg_addr) >= S1) && (int'(reg_addr) < S1 + NB);

    // R10
    status_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && s1_hit0) |=> (reg_rdata == $past(stat0[7:0])));

    // R6
    cor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cor && reg_rd && s1_hit0) |=>
        ((stat0[7:0] & $past(stat0[7:0]) & ~$past(pend_x[7:0])
          & ~$past(ev_x[7:0])) == 8'h00));

    // R5
    w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cor && !(reg_wr && s1_any)) |=> ((~stat0 & $past(stat0)) == '0));

    // R4
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_irq_n[0]) |-> ($past(reg_wr) || ((stat0 & ~$past(stat0)) != '0)));

    // R2
    stat_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat0 & ~$past(stat0) & ~$past(ev_x) & ~$past(pend_x)) == '0));

    // R7
    pend_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_x & ~stat0) == '0));

    if (NSRC % 8 != 0) begin : g_pad_chk
        localparam int LOWB = NSRC % 8;
        // R9
        stat_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_addr == ADDR_W'(S1 + NB - 1)) |=>
            (reg_rdata[7:LOWB] == '0));
    end

endmodule

bind dual_host_irq_bank dual_host_irq_bank_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .host_irq_n (host_irq_n),
    .cor        (cor_q),
    .ev         (ev_v),
    .stat0      (stat_pad[0]),
    .pend0      (g_line[0].u_bank.pend_q)
);

// File: tb/tb_dual_host_irq_bank.sv
`timescale 1ns/1ps
module tb_dual_host_irq_bank;

    localparam int NSRC   = 22;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_in = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic [1:0]        host_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    dual_host_irq_bank #(.NSRC(NSRC), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_irq_n(host_irq_n)
    );

    // monitor: a read sampled at an edge is compared just after that edge
    always @(posedge clk) begin
        logic was_rd;
        logic [7:0] e;
        string t;
        was_rd = reg_rd;
        #1;
        if (was_rd && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual %02h expected %02h", t, reg_rdata, e);
            end
        end
    end

    task automatic wr_reg(input int a, input logic [7:0] d);
        reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_exp(input int a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        reg_addr = ADDR_W'(a); reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic [1:0] e, input string t);
        checks++;
        if (host_irq_n !== e) begin
            errors++;
            $display("FAIL %s: host_irq_n actual %b expected %b", t, host_irq_n, e);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // map for NSRC=22: edge 0-5, S1 6-8, M1 9-11, S2 12-14, M2 15-17, ctrl 18
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_exp(9,  8'hFF, "R1 mask1 b0");
        rd_exp(11, 8'hFF, "R1 mask1 b2");
        rd_exp(0,  8'h00, "R1 edge b0");
        rd_exp(6,  8'h00, "R1 stat1 b0");
        rd_exp(18, 8'h00, "R1 ctrl");
        chk_irq(2'b11, "R1 irq");
        rd_exp(25, 8'h00, "R9 unmapped");

        // R2 rising edge on source 0, R3 both lines
        wr_reg(0, 8'h02);
        src_in[0] = 1'b1; settle();
        rd_exp(6,  8'h01, "R2 rise src0");
        rd_exp(12, 8'h01, "R3 line2 set");
        chk_irq(2'b11, "R4 masked");
        wr_reg(9, 8'hFE);
        chk_irq(2'b10, "R4 line1 unmasked");
        rd_exp(6, 8'h01, "R5 read no clear");
        wr_reg(6, 8'h00);
        rd_exp(6, 8'h01, "R5 write zero keeps");
        wr_reg(6, 8'h01);
        rd_exp(6, 8'h00, "R5 w1c");
        chk_irq(2'b11, "R4 cleared");
        rd_exp(12, 8'h01, "R3 line2 independent");
        wr_reg(12, 8'h01);
        rd_exp(12, 8'h00, "R5 w1c line2");

        // R2 falling edge on source 1, disabled source 2
        wr_reg(0, 8'h04);
        src_in[1] = 1'b1; src_in[2] = 1'b1; settle();
        rd_exp(6, 8'h00, "R2 rise ignored");
        src_in[1] = 1'b0; src_in[2] = 1'b0; settle();
        rd_exp(6, 8'h02, "R2 fall src1 only");
        rd_exp(0, 8'h04, "R2 edge readback");
        wr_reg(6, 8'h02); wr_reg(12, 8'h02);

        // R6 clear-on-read
        wr_reg(18, 8'h01);
        rd_exp(18, 8'h01, "R6 ctrl");
        src_in[1] = 1'b1; settle();
        src_in[1] = 1'b0; settle();
        rd_exp(6, 8'h02, "R6 read returns");
        rd_exp(6, 8'h00, "R6 read cleared");
        wr_reg(12, 8'h02);
        rd_exp(12, 8'h02, "R6 write ignored");
        rd_exp(12, 8'h00, "R6 line2 cleared");

        // R7 second event buffered
        wr_reg(0, 8'h02);
        src_in[0] = 1'b0; settle();
        src_in[0] = 1'b1; settle();
        src_in[0] = 1'b0; settle();
        src_in[0] = 1'b1; settle();
        rd_exp(6, 8'h01, "R7 first");
        rd_exp(6, 8'h01, "R7 buffered");
        rd_exp(6, 8'h00, "R7 drained");
        rd_exp(12, 8'h01, "R7 line2 first");
        rd_exp(12, 8'h01, "R7 line2 buffered");
        rd_exp(12, 8'h00, "R7 line2 drained");

        // R8 edge coinciding with clear-on-read
        src_in[0] = 1'b0; settle();
        src_in[0] = 1'b1; settle();
        src_in[0] = 1'b0; settle();
        src_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd_exp(6, 8'h01, "R8 read at edge");
        rd_exp(6, 8'h01, "R8 edge won");
        rd_exp(6, 8'h00, "R8 no extra");
        rd_exp(12, 8'h01, "R7 line2 a");
        rd_exp(12, 8'h01, "R7 line2 b");
        rd_exp(12, 8'h00, "R7 line2 c");

        // R9 padding, R2 upper byte position
        wr_reg(5, 8'hFF);
        rd_exp(5, 8'h0F, "R9 edge pad");
        src_in[21] = 1'b1; settle();
        rd_exp(8, 8'h20, "R2 src21 byte2");
        src_in[21] = 1'b0; settle();
        wr_reg(11, 8'hDF);
        chk_irq(2'b10, "R4 src21 unmasked");
        rd_exp(8, 8'h20, "R9 status pad zero");
        chk_irq(2'b11, "R4 after cor");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule